// File: doc/BRIEF.md
# Flash Command Control Register

This block is the control and status front end of a flash memory controller. Software programs a target address, four data words and a clock divider. It then writes a command word that asks for a word write, a page erase or a whole-array erase. A command starts only if the same write carries the open key, and an erase starts only if it also carries the matching erase code. A request that breaks these rules does not start. It raises an access-fault flag instead.

While an operation runs, a pending bit in the command register stays set and writes to that register are dropped. The flash array is modelled as a stub timer. It counts a fixed number of slow ticks per operation, and each tick lasts a programmable number of system clocks. When the operation ends, the command bits and the pending bit clear themselves and a done flag is raised. Each of the two flags has an enable bit, and the interrupt line is high while any enabled flag is set.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0x3000_0000 (key field 0x3, nothing pending), the interrupt register reads 0, the divider reads DIV_RESET, and `irq`, `fl_busy` and `fl_start` are low.
- R2: The address register (offset 0x00) and the data words (offsets 0x30, 0x34, 0x38, 0x3C) read back what was written. The divider (offset 0x04) keeps bits 7:0 only.
- R3: The command register is at offset 0x08, with write request in bit 0, whole-array erase in bit 1, page erase in bit 2, erase code in bits 15:8, pending in bit 24 and key in bits 31:28. A legal command sets pending on the writing clock edge. For the following cycle it drives `fl_start` high and drives `fl_op` with 1 for a write, 2 for a page erase or 3 for a whole erase.
- R4: A page erase needs erase code 0x55 and a whole erase needs 0xAA. A write request starts whatever the code field holds.
- R5: A command is refused if the key is not 0x2, if the erase code is wrong, or if more than one request bit is set. A refused command sets the fault flag (interrupt register bit 1), leaves pending clear and produces no `fl_start`.
- R6: An operation ends exactly N × D clocks after the accepting edge. D is the divider value and N is WRITE_TICKS, PAGE_TICKS or MASS_TICKS. On that edge the request bits and pending clear and the done flag (interrupt register bit 0) sets.
- R7: Writes to the command register while pending is set change nothing: the register keeps its value, no fault is raised and the completion time is unchanged.
- R8: Writing the interrupt register at offset 0x24 clears each flag whose bit is written 0 and leaves each flag whose bit is written 1. The done enable is stored in bit 8 and the fault enable in bit 9.
- R9: `irq` is high exactly when (done and its enable) or (fault and its enable) holds.
- R10: A divider value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fl_start | output | 1 | One-cycle start pulse to the flash stub |
| fl_op | output | 2 | Running operation (0 none, 1 write, 2 page, 3 whole) |
| fl_busy | output | 1 | Flash stub busy |
| fl_addr | output | 32 | Target address for the flash |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a command register write that arrives while an operation is still counting. It must leave no trace: no new fields, no fault and no shift in the completion edge. The bench starts a write operation with a short divider and then, mid-operation, writes a legal whole-erase command. It reads the register back and times completion against a free-running cycle counter. A table of command words covers the refusal rules one at a time: wrong key, wrong code for each erase type, two request bits, and a divider of zero.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PAGE  = 2'd2,
        OP_MASS  = 2'd3
    } fop_e;

    localparam logic [7:0] OFF_ADDR = 8'h00;
    localparam logic [7:0] OFF_DIV  = 8'h04;
    localparam logic [7:0] OFF_CTRL = 8'h08;
    localparam logic [7:0] OFF_IRQ  = 8'h24;
    localparam logic [7:0] OFF_DATA = 8'h30;

    localparam logic [7:0] CODE_PAGE = 8'h55;
    localparam logic [7:0] CODE_MASS = 8'hAA;
    localparam logic [3:0] KEY_OPEN  = 4'h2;
    localparam logic [3:0] KEY_SHUT  = 4'h3;

    typedef struct packed {
        logic [3:0] key;
        logic [2:0] rsv_hi;
        logic       pend;
        logic [7:0] rsv_mid;
        logic [7:0] code;
        logic [4:0] rsv_lo;
        logic       page;
        logic       mass;
        logic       wr;
    } ctrl_t;

    typedef struct packed {
        logic go;
        logic bad;
        fop_e op;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(ctrl_t w);
        cmd_dec_t r;
        logic [1:0] nreq;
        r.go  = 1'b0;
        r.bad = 1'b0;
        r.op  = OP_NONE;
        nreq  = {1'b0, w.wr} + {1'b0, w.mass} + {1'b0, w.page};
        if (nreq != 2'd0) begin
            if (w.key != KEY_OPEN || nreq != 2'd1)
                r.bad = 1'b1;
            else if (w.page && w.code != CODE_PAGE)
                r.bad = 1'b1;
            else if (w.mass && w.code != CODE_MASS)
                r.bad = 1'b1;
            else begin
                r.go = 1'b1;
                r.op = w.wr ? OP_WRITE : (w.page ? OP_PAGE : OP_MASS);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/flc_tick_gen.sv
module flc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             last;

    // a divider of 0 or 1 gives one tick per clock
    assign last = (div <= 1) ? 1'b1 : (cnt == div - 1'b1);
    assign tick = en & last;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= last ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/flc_op_timer.sv
module flc_op_timer
    import flc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WRITE_TICKS = 3,
    parameter int PAGE_TICKS  = 5,
    parameter int MASS_TICKS  = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  fop_e op_in,
    input  logic tick,
    output logic busy,
    output logic done,
    output fop_e op_q
);
    logic [CNT_W-1:0] remain;

    function automatic logic [CNT_W-1:0] ticks_for(fop_e op);
        case (op)
            OP_WRITE: return CNT_W'(WRITE_TICKS);
            OP_PAGE:  return CNT_W'(PAGE_TICKS);
            OP_MASS:  return CNT_W'(MASS_TICKS);
            default:  return CNT_W'(1);
        endcase
    endfunction

    assign done = busy & tick & (remain == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            op_q   <= OP_NONE;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= ticks_for(op_in);
            op_q   <= op_in;
        end else if (done) begin
            busy   <= 1'b0;
            remain <= '0;
            op_q   <= OP_NONE;
        end else if (busy && tick) begin
            remain <= remain - 1'b1;
        end
    end

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);
    p_remain_live_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> remain != '0);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flc_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         DW          = 32,
    parameter int         DIV_W       = 8,
    parameter int         NDATA       = 4,
    parameter int         CNT_W       = 8,
    parameter int         WRITE_TICKS = 3,
    parameter int         PAGE_TICKS  = 5,
    parameter int         MASS_TICKS  = 7,
    parameter logic [7:0] DIV_RESET   = 8'd48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          fl_start,
    output logic [1:0]    fl_op,
    output logic          fl_busy,
    output logic [DW-1:0] fl_addr,
    output logic          irq
);
    localparam int BYTES = DW / 8;

    logic [DW-1:0]    addr_q;
    logic [DIV_W-1:0] div_q;
    logic [DW-1:0]    data_q [NDATA];
    ctrl_t            ctrl_q;
    logic             done_f, fault_f, done_en, fault_en;

    cmd_dec_t dec;
    logic     wr_ctrl, wr_irq, accept, reject;
    logic     tick, busy, op_done;
    fop_e     op_q;

    assign dec     = decode_cmd(ctrl_t'(reg_wdata));
    assign wr_ctrl = reg_we && reg_addr == AW'(OFF_CTRL) && !ctrl_q.pend;
    assign wr_irq  = reg_we && reg_addr == AW'(OFF_IRQ);
    assign accept  = wr_ctrl & dec.go;
    assign reject  = wr_ctrl & dec.bad;

    flc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .clr(accept), .en(busy), .div(div_q), .tick(tick)
    );

    flc_op_timer #(
        .CNT_W(CNT_W), .WRITE_TICKS(WRITE_TICKS),
        .PAGE_TICKS(PAGE_TICKS), .MASS_TICKS(MASS_TICKS)
    ) u_timer (
        .clk(clk), .rst(rst), .start(accept), .op_in(dec.op), .tick(tick),
        .busy(busy), .done(op_done), .op_q(op_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            div_q  <= DIV_W'(DIV_RESET);
        end else if (reg_we) begin
            if (reg_addr == AW'(OFF_ADDR)) addr_q <= reg_wdata;
            if (reg_addr == AW'(OFF_DIV))  div_q  <= reg_wdata[DIV_W-1:0];
        end
    end

    for (genvar i = 0; i < NDATA; i++) begin : g_data
        always_ff @(posedge clk) begin
            if (rst)
                data_q[i] <= '0;
            else if (reg_we && reg_addr == AW'(OFF_DATA) + AW'(BYTES * i))
                data_q[i] <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            ctrl_q.key <= KEY_SHUT;
        end else if (op_done) begin
            ctrl_q.wr   <= 1'b0;
            ctrl_q.mass <= 1'b0;
            ctrl_q.page <= 1'b0;
            ctrl_q.pend <= 1'b0;
        end else if (wr_ctrl && !dec.bad) begin
            ctrl_q.wr   <= reg_wdata[0];
            ctrl_q.mass <= reg_wdata[1];
            ctrl_q.page <= reg_wdata[2];
            ctrl_q.code <= reg_wdata[15:8];
            ctrl_q.key  <= reg_wdata[31:28];
            ctrl_q.pend <= dec.go;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_start <= 1'b0;
            done_f   <= 1'b0;
            fault_f  <= 1'b0;
            done_en  <= 1'b0;
            fault_en <= 1'b0;
        end else begin
            fl_start <= accept;
            done_f   <= op_done | (done_f & (!wr_irq | reg_wdata[0]));
            fault_f  <= reject  | (fault_f & (!wr_irq | reg_wdata[1]));
            if (wr_irq) begin
                done_en  <= reg_wdata[8];
                fault_en <= reg_wdata[9];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(OFF_ADDR): reg_rdata = addr_q;
            AW'(OFF_DIV):  reg_rdata = DW'(div_q);
            AW'(OFF_CTRL): reg_rdata = DW'(ctrl_q);
            AW'(OFF_IRQ):  reg_rdata = DW'({fault_en, done_en, 6'b0, fault_f, done_f});
            default: begin
                for (int i = 0; i < NDATA; i++)
                    if (reg_addr == AW'(OFF_DATA) + AW'(BYTES * i))
                        reg_rdata = data_q[i];
            end
        endcase
    end

    assign fl_op   = op_q;
    assign fl_busy = busy;
    assign fl_addr = addr_q;
    assign irq     = (done_f & done_en) | (fault_f & fault_en);

    p_pend_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pend == busy);
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        fl_start |=> !fl_start);
    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        fl_start |-> busy && op_q != OP_NONE);
    p_done_flag_r6: assert property (@(posedge clk) disable iff (rst)
        op_done |=> done_f && !ctrl_q.pend);
    p_fault_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_f) |-> !busy && !fl_start);
    p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pend && !op_done |=> $stable(ctrl_q.key) && $stable(ctrl_q.code));

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int         WT = 3;
    localparam int         PT = 5;
    localparam int         MT = 7;
    localparam logic [7:0] DRST = 8'd10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fl_start, fl_busy, irq;
    logic [1:0]  fl_op;
    logic [31:0] fl_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_ctrl #(
        .WRITE_TICKS(WT), .PAGE_TICKS(PT), .MASS_TICKS(MT), .DIV_RESET(DRST)
    ) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_start(fl_start),
        .fl_op(fl_op), .fl_busy(fl_busy), .fl_addr(fl_addr), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] cw;
        logic [7:0]  dv;
        logic        go;
        logic [1:0]  op;
        logic [7:0]  nt;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{32'h2000_0001, 8'd2, 1'b1, 2'd1, 8'(WT)},
        '{32'h2000_5504, 8'd3, 1'b1, 2'd2, 8'(PT)},
        '{32'h2000_AA02, 8'd1, 1'b1, 2'd3, 8'(MT)},
        '{32'h3000_0001, 8'd2, 1'b0, 2'd0, 8'd0},
        '{32'h2000_AA04, 8'd2, 1'b0, 2'd0, 8'd0},
        '{32'h2000_5502, 8'd2, 1'b0, 2'd0, 8'd0},
        '{32'h2000_0003, 8'd2, 1'b0, 2'd0, 8'd0},
        '{32'h2000_5504, 8'd0, 1'b1, 2'd2, 8'(PT)},
        '{32'h2000_0000, 8'd2, 1'b0, 2'd0, 8'd0},
        '{32'h2000_7701, 8'd4, 1'b1, 2'd1, 8'(WT)}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_idle(input int t0, output int elapsed);
        logic [31:0] v;
        int guard = 0;
        rd(8'h08, v);
        while (v[24] && guard < 3000) begin
            rd(8'h08, v);
            guard++;
        end
        elapsed = cyc - t0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int t0, el, d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(8'h08, v); check("R1 ctrl", v, 32'h3000_0000);
        rd(8'h24, v); check("R1 irqreg", v, 32'h0);
        rd(8'h04, v); check("R1 div", v, 32'(DRST));
        check("R1 pins", {29'b0, irq, fl_busy, fl_start}, 32'h0);

        // R2 readback
        wr(8'h00, 32'hDEAD_0100);
        rd(8'h00, v); check("R2 addr", v, 32'hDEAD_0100);
        check("R2 fl_addr", fl_addr, 32'hDEAD_0100);
        for (int i = 0; i < 4; i++) wr(8'h30 + 8'(4 * i), 32'h1111_0000 + 32'(i));
        for (int i = 0; i < 4; i++) begin
            rd(8'h30 + 8'(4 * i), v); check("R2 data", v, 32'h1111_0000 + 32'(i));
        end
        wr(8'h04, 32'hABCD_1234);
        rd(8'h04, v); check("R2 div8", v, 32'h34);

        // table walk: R3 R4 R5 R6 R10
        for (int k = 0; k < 10; k++) begin
            wr(8'h24, 32'h0);
            wr(8'h04, 32'(VEC[k].dv));
            wr(8'h08, VEC[k].cw);
            t0 = cyc;
            check("R3 start", {31'b0, fl_start}, {31'b0, VEC[k].go});
            if (VEC[k].go) check("R3 op", {30'b0, fl_op}, {30'b0, VEC[k].op});
            rd(8'h08, v);
            check("R3 pend", {31'b0, v[24]}, {31'b0, VEC[k].go});
            if (VEC[k].go) begin
                d = (VEC[k].dv == 0) ? 1 : int'(VEC[k].dv);
                wait_idle(t0, el);
                check(VEC[k].dv == 0 ? "R10 duration" : "R6 duration", el, VEC[k].nt * d);
                rd(8'h08, v); check("R6 bits clear", v & 32'h0100_0007, 32'h0);
                rd(8'h24, v); check("R6 done flag", v, 32'h1);
            end else begin
                rd(8'h24, v);
                check("R5 fault flag", {31'b0, v[1]}, {31'b0, |VEC[k].cw[2:0]});
                if (VEC[k].cw[2:0] == 3'b0) begin
                    rd(8'h08, v); check("R4 fields stored", v, VEC[k].cw);
                end
            end
        end

        // R7 write while pending is dropped
        wr(8'h24, 32'h0);
        wr(8'h04, 32'd2);
        wr(8'h08, 32'h2000_0001);
        t0 = cyc;
        wr(8'h08, 32'h2000_AA02);
        wr(8'h08, 32'h3000_0004);
        rd(8'h08, v); check("R7 unchanged", v, 32'h2100_0001);
        check("R7 op", {30'b0, fl_op}, 32'd1);
        wait_idle(t0, el);
        check("R7 duration", el, WT * 2);
        rd(8'h24, v); check("R7 no fault", v, 32'h1);

        // R8 / R9 flag clearing and irq
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h3000_0001);
        rd(8'h24, v); check("R8 both flags", v, 32'h3);
        wr(8'h24, 32'h0000_0302);
        rd(8'h24, v); check("R8 keep fault", v, 32'h302);
        check("R9 irq fault", {31'b0, irq}, 32'h1);
        wr(8'h24, 32'h0000_0100);
        rd(8'h24, v); check("R8 cleared", v, 32'h100);
        check("R9 irq low", {31'b0, irq}, 32'h0);
        wr(8'h04, 32'd1);
        wr(8'h08, 32'h2000_0001);
        repeat (WT + 2) @(posedge clk);
        #1 check("R9 irq done", {31'b0, irq}, 32'h1);
        wr(8'h24, 32'h0000_0200);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule